// File: doc/BRIEF.md
# Register-to-register execution unit

This block is the execute and writeback stage of a 16-bit load-store processor for three-register instructions. Each cycle in which `valid_i` is high, it takes an opcode, two operand values already read from the register file, and a destination index. It works out the result in the same cycle and raises up to two write requests. The block holds the 16-entry register file that those requests update at the next rising clock edge. A read port lets the surrounding pipeline, or a bench, look at any register.

Divide is the only operation that writes two registers at once. The quotient goes to the named destination and the remainder goes to the last register, index 15, no matter which registers the instruction names. A division by zero does not stop the block. It writes zeros and sets an error flag that stays set until reset.

Top module: `rrr_exec_unit`

## Requirements
- R1: Opcodes are encoded as: 0 add, 1 subtract, 2 multiply, 3 divide, 4 equal, 5 signed less-than, 6 signed greater-than, 7 and, 8 or, 9 xor, 10 not, 11 shift left, 12 shift right. Add computes a+b and subtract computes a-b, both modulo 2^16.
- R2: Multiply treats a and b as two's complement values and writes the low 16 bits of the product.
- R3: Divide writes the truncated signed quotient a/b on write port A to the destination. On write port B it writes the remainder, which has the sign of a, to register 15. For a = 0x8000 and b = 0xFFFF the quotient is 0x8000 and the remainder is 0.
- R4: A divide with b = 0 writes 0 as both quotient and remainder. It sets `div_err_o` from the next cycle on, and the flag stays high until reset.
- R5: When a divide names register 15 as its destination, port A raises no request, and register 15 ends up holding the remainder.
- R6: Equal compares the raw bit patterns. Less-than and greater-than compare a with b as signed values. A true result is written as 1 and a false result as 0.
- R7: And, or and xor combine a and b bit by bit. Not writes the inversion of a, and b is unused.
- R8: Shift left moves a up by b places with zero fill. Shift right moves a down by b places with zero fill. In both cases b is read as an unsigned count.
- R9: A shift count of 16 or more gives 0.
- R10: Register 0 always reads 0, and port A never requests a write to it. A divide naming register 0 still writes its remainder to register 15.
- R11: After reset every register reads 0 and `div_err_o` is low. With `valid_i` low, or with opcodes 13 to 15, no write request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Opcode |
| dst_i | input | 4 | Destination register index |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand or shift count |
| wr_a_en_o | output | 1 | Primary write request |
| wr_a_idx_o | output | 4 | Primary write index |
| wr_a_data_o | output | 16 | Primary write data |
| wr_b_en_o | output | 1 | Remainder write request |
| wr_b_idx_o | output | 4 | Remainder write index (always 15) |
| wr_b_data_o | output | 16 | Remainder write data |
| rd_idx_i | input | 4 | Read port index |
| rd_data_o | output | 16 | Read port data |
| div_err_o | output | 1 | Sticky divide-by-zero flag |

## Verification
Every opcode, including the three unused ones, is run against every pair drawn from a set of fourteen operands. The set holds zero, one, small counts, values on both sides of 16, the two signed extremes, all-ones and mixed bit patterns. Sign bugs in multiply, divide and the ordering compares show up as mismatches around 0x7FFF, 0x8000 and 0xFFFF. Shift-fill and count-limit bugs show up on the counts 15, 16 and 17. A separate sweep walks the shift count from 0 to 20 to locate the exact boundary. Directed cases with destination 0 and destination 15, and divides by zero placed before and after other operations, separate the write-priority behaviour from the sticky flag.

// File: rtl/rrr_pkg.sv
package rrr_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_MUL = 4'd2,
    OP_DIV = 4'd3,
    OP_EQ  = 4'd4,
    OP_LT  = 4'd5,
    OP_GT  = 4'd6,
    OP_AND = 4'd7,
    OP_OR  = 4'd8,
    OP_XOR = 4'd9,
    OP_NOT = 4'd10,
    OP_SHL = 4'd11,
    OP_SHR = 4'd12
  } rrr_op_e;
endpackage

// File: rtl/rrr_shifter.sv
module rrr_shifter #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] cnt_i,
  input  logic         left_i,
  output logic [W-1:0] res_o
);
  localparam int unsigned SW = $clog2(W);

  logic [W-1:0] stg [SW+1];
  logic         big;

  // any count bit at or above SW means count >= W
  assign big    = |cnt_i[W-1:SW];
  assign stg[0] = val_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    always_comb begin
      if (!cnt_i[k])   stg[k+1] = stg[k];
      else if (left_i) stg[k+1] = stg[k] << (2**k);
      else             stg[k+1] = stg[k] >> (2**k);
    end
  end

  assign res_o = big ? '0 : stg[SW];
endmodule

// File: rtl/rrr_divider.sv
module rrr_divider #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         zero_o
);
  localparam int unsigned XW = 2 * W;

  logic signed [XW-1:0] num_x, den_x, quo_x, rem_x;

  // widened operands keep min/-1 from trapping; truncation wraps it
  assign num_x  = {{W{num_i[W-1]}}, num_i};
  assign den_x  = {{W{den_i[W-1]}}, den_i};
  assign zero_o = (den_i == '0);

  always_comb begin
    if (zero_o) begin
      quo_x = '0;
      rem_x = '0;
    end else begin
      quo_x = num_x / den_x;
      rem_x = num_x % den_x;
    end
  end

  assign quo_o = quo_x[W-1:0];
  assign rem_o = rem_x[W-1:0];
endmodule

// File: rtl/rrr_alu.sv
module rrr_alu
  import rrr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  rrr_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         wr_o,
  output logic         is_div_o,
  output logic [W-1:0] rem_o,
  output logic         div0_o
);
  localparam int unsigned PW = 2 * W;

  logic [W-1:0]         sh_res, quo;
  logic signed [PW-1:0] prod;
  logic                 flag;

  rrr_shifter #(.W(W)) u_shift (
    .val_i (a_i),
    .cnt_i (b_i),
    .left_i(op_i == OP_SHL),
    .res_o (sh_res)
  );

  rrr_divider #(.W(W)) u_div (
    .num_i (a_i),
    .den_i (b_i),
    .quo_o (quo),
    .rem_o (rem_o),
    .zero_o(div0_o)
  );

  assign prod = $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i});

  always_comb begin
    flag  = 1'b0;
    res_o = '0;
    wr_o  = 1'b1;
    unique case (op_i)
      OP_ADD: res_o = a_i + b_i;
      OP_SUB: res_o = a_i - b_i;
      OP_MUL: res_o = prod[W-1:0];
      OP_DIV: res_o = quo;
      OP_EQ:  flag  = (a_i == b_i);
      OP_LT:  flag  = ($signed(a_i) < $signed(b_i));
      OP_GT:  flag  = ($signed(a_i) > $signed(b_i));
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_NOT: res_o = ~a_i;
      OP_SHL, OP_SHR: res_o = sh_res;
      default: wr_o = 1'b0;
    endcase
    if (op_i inside {OP_EQ, OP_LT, OP_GT}) res_o = {{(W-1){1'b0}}, flag};
  end

  assign is_div_o = (op_i == OP_DIV);
endmodule

// File: rtl/rrr_regfile.sv
module rrr_regfile #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wa_en_i,
  input  logic [IW-1:0] wa_idx_i,
  input  logic [W-1:0]  wa_data_i,
  input  logic          wb_en_i,
  input  logic [IW-1:0] wb_idx_i,
  input  logic [W-1:0]  wb_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0] rd_vec [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [W-1:0] q;
    if (i == 0) begin : g_zero
      assign q = '0;
    end else begin : g_live
      // port B wins over port A on the same index
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                               q <= '0;
        else if (wb_en_i && wb_idx_i == IW'(i))    q <= wb_data_i;
        else if (wa_en_i && wa_idx_i == IW'(i))    q <= wa_data_i;
      end
    end
    assign rd_vec[i] = q;
  end

  assign rd_data_o = rd_vec[rd_idx_i];
endmodule

// File: rtl/rrr_exec_unit.sv
module rrr_exec_unit
  import rrr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REG_N  = 16,
  localparam int unsigned IDX_W = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [IDX_W-1:0]  dst_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              wr_a_en_o,
  output logic [IDX_W-1:0]  wr_a_idx_o,
  output logic [DATA_W-1:0] wr_a_data_o,
  output logic              wr_b_en_o,
  output logic [IDX_W-1:0]  wr_b_idx_o,
  output logic [DATA_W-1:0] wr_b_data_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              div_err_o
);
  localparam logic [IDX_W-1:0] REM_IDX = IDX_W'(REG_N - 1);

  logic [DATA_W-1:0] res, rem;
  logic              alu_wr, is_div, div0, err_q;

  rrr_alu #(.W(DATA_W)) u_alu (
    .op_i    (rrr_op_e'(op_i)),
    .a_i     (a_i),
    .b_i     (b_i),
    .res_o   (res),
    .wr_o    (alu_wr),
    .is_div_o(is_div),
    .rem_o   (rem),
    .div0_o  (div0)
  );

  // remainder owns the last register when both target it
  assign wr_a_en_o   = valid_i && alu_wr && (dst_i != '0) && !(is_div && dst_i == REM_IDX);
  assign wr_a_idx_o  = dst_i;
  assign wr_a_data_o = res;
  assign wr_b_en_o   = valid_i && is_div;
  assign wr_b_idx_o  = REM_IDX;
  assign wr_b_data_o = rem;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        err_q <= 1'b0;
    else if (valid_i && is_div && div0) err_q <= 1'b1;
  end
  assign div_err_o = err_q;

  rrr_regfile #(.W(DATA_W), .N(REG_N)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wa_en_i  (wr_a_en_o),
    .wa_idx_i (wr_a_idx_o),
    .wa_data_i(wr_a_data_o),
    .wb_en_i  (wr_b_en_o),
    .wb_idx_i (wr_b_idx_o),
    .wb_data_i(wr_b_data_o),
    .rd_idx_i (rd_idx_i),
    .rd_data_o(rd_data_o)
  );

  AST_REM_TO_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_DIV |-> wr_b_en_o && wr_b_idx_o == REM_IDX); // R3
  AST_NO_WRITE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_a_en_o |-> wr_a_idx_o != '0); // R10
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_err_o |=> div_err_o); // R4
  AST_DIV0_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_DIV && b_i == '0 |-> wr_b_data_o == '0 ##1 div_err_o); // R4
  AST_CMP_BOOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i inside {OP_EQ, OP_LT, OP_GT} |-> wr_a_data_o[DATA_W-1:1] == '0); // R6
  AST_SHIFT_BIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i inside {OP_SHL, OP_SHR} && b_i >= DATA_W |-> wr_a_data_o == '0); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !wr_a_en_o && !wr_b_en_o); // R11
endmodule

// File: tb/rrr_exec_unit_tb_top.sv
module rrr_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = '0, dst = '0, rd_idx = '0;
  logic [15:0] a = '0, b = '0;
  logic        wa_en, wb_en, err;
  logic [3:0]  wa_idx, wb_idx;
  logic [15:0] wa_data, wb_data, rd_data;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model [16];
  logic        m_err = 1'b0;

  always #4 clk = ~clk;

  rrr_exec_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .dst_i(dst),
    .a_i(a), .b_i(b), .wr_a_en_o(wa_en), .wr_a_idx_o(wa_idx), .wr_a_data_o(wa_data),
    .wr_b_en_o(wb_en), .wr_b_idx_o(wb_idx), .wr_b_data_o(wb_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .div_err_o(err)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h dst=%0d act=%h exp=%h", req, op, a, b, dst, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4, 4'd5, 4'd6: return "R6";
      4'd7, 4'd8, 4'd9, 4'd10: return "R7";
      4'd11, 4'd12: return "R8";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [15:0] model_res(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y,
                                            output logic [15:0] r, output bit wr);
    logic signed [31:0] sx, sy, t;
    sx = $signed({{16{x[15]}}, x});
    sy = $signed({{16{y[15]}}, y});
    r  = '0;
    wr = 1'b1;
    case (o)
      4'd0: return x + y;
      4'd1: return x - y;
      4'd2: begin t = sx * sy; return t[15:0]; end
      4'd3: begin
        if (y == 0) return 16'h0;
        t = sx % sy; r = t[15:0];
        t = sx / sy; return t[15:0];
      end
      4'd4: return {15'd0, x == y};
      4'd5: return {15'd0, sx < sy};
      4'd6: return {15'd0, sx > sy};
      4'd7: return x & y;
      4'd8: return x | y;
      4'd9: return x ^ y;
      4'd10: return ~x;
      4'd11: return (y >= 16) ? 16'h0 : x << y[3:0];
      4'd12: return (y >= 16) ? 16'h0 : x >> y[3:0];
      default: begin wr = 1'b0; return 16'h0; end
    endcase
  endfunction

  task automatic run_op(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y, input logic [3:0] d);
    logic [15:0] e_res, e_rem;
    bit          e_wr, e_wa, e_wb;
    string       rq;
    @(negedge clk);
    op = o; a = x; b = y; dst = d; valid = 1'b1;
    #1;
    e_res = model_res(o, x, y, e_rem, e_wr);
    e_wb  = (o == 4'd3);
    e_wa  = e_wr && d != 0 && !(e_wb && d == 15);
    rq    = (d == 0) ? "R10" : (e_wb && d == 15) ? "R5" : (e_wb && y == 0) ? "R4" :
            (o inside {4'd11, 4'd12} && y >= 16) ? "R9" : req_of(o);
    chk(wa_en == e_wa, rq, {15'd0, wa_en}, {15'd0, e_wa});
    if (e_wa) chk(wa_data == e_res && wa_idx == d, rq, wa_data, e_res);
    chk(wb_en == e_wb, rq, {15'd0, wb_en}, {15'd0, e_wb});
    if (e_wb) chk(wb_data == e_rem && wb_idx == 4'd15, rq, wb_data, e_rem);
    @(posedge clk);
    if (e_wa) model[d] = e_res;
    if (e_wb) model[15] = e_rem;
    if (e_wb && y == 0) m_err = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    rd_idx = d;
    #1 chk(rd_data == model[d], rq, rd_data, model[d]);
    if (e_wb) begin
      rd_idx = 4'd15;
      #1 chk(rd_data == model[15], rq, rd_data, model[15]);
    end
    chk(err == m_err, "R4", {15'd0, err}, {15'd0, m_err});
  endtask

  function automatic logic [15:0] pick(input int i);
    case (i)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;  3: return 16'h0003;
      4: return 16'h000F;  5: return 16'h0010;  6: return 16'h0011;  7: return 16'h7FFF;
      8: return 16'h8000;  9: return 16'h8001;  10: return 16'hFFFF; 11: return 16'h00F0;
      12: return 16'hA5C3; default: return 16'hFFFE;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i);
      #1 chk(rd_data == 16'h0, "R11", rd_data, 16'h0);
    end
    chk(err == 1'b0 && !wa_en && !wb_en, "R11", {15'd0, err}, 16'h0);

    // full sweep over nonzero-divisor pairs first so the flag check stays distinct
    n = 0;
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 14; i++)
        for (int j = 0; j < 14; j++) begin
          if (!(o == 3 && pick(j) == 0)) begin
            run_op(4'(o), pick(i), pick(j), 4'(1 + n % 14));
            n++;
          end
        end
    chk(err == 1'b0, "R4", {15'd0, err}, 16'h0);

    // R9 shift count boundary walk
    for (int c = 0; c <= 20; c++) begin
      run_op(4'd11, 16'hB3C5, 16'(c), 4'd3);
      run_op(4'd12, 16'hB3C5, 16'(c), 4'd4);
    end
    run_op(4'd11, 16'hFFFF, 16'h8000, 4'd5); // R9 large count
    run_op(4'd12, 16'hFFFF, 16'h0100, 4'd5); // R9

    // R3 signed extreme
    run_op(4'd3, 16'h8000, 16'hFFFF, 4'd6);
    run_op(4'd3, 16'hFFF9, 16'h0002, 4'd6);   // -7/2 -> -3 rem -1
    // R10 writes to register 0 ignored, remainder still lands
    run_op(4'd0, 16'h1234, 16'h0001, 4'd0);
    run_op(4'd3, 16'd17, 16'd5, 4'd0);
    // R5 divide naming register 15
    run_op(4'd3, 16'd23, 16'd4, 4'd15);
    run_op(4'd0, 16'h0100, 16'h0001, 4'd15); // non-divide writes 15 normally
    // R4 divide by zero, then flag stays set
    run_op(4'd3, 16'h1234, 16'h0000, 4'd7);
    run_op(4'd0, 16'h0001, 16'h0001, 4'd8);
    run_op(4'd3, 16'd9, 16'd3, 4'd9);
    chk(err == 1'b1, "R4", {15'd0, err}, 16'h1);

    // R11 valid low writes nothing
    @(negedge clk);
    valid = 1'b0; op = 4'd0; a = 16'h5555; b = 16'h1111; dst = 4'd2;
    #1 chk(!wa_en && !wb_en, "R11", {15'd0, wa_en}, 16'h0);
    @(negedge clk);
    rd_idx = 4'd2;
    #1 chk(rd_data == model[2], "R11", rd_data, model[2]);

    // R4 flag cleared by reset
    rst_n = 1'b0;
    #1 chk(err == 1'b0, "R4", {15'd0, err}, 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule